// File: doc/BRIEF.md
# MSB-First Word Serializer

This block converts a parallel word into a one-bit serial stream. The fast bit clock is its only clock. A divider elsewhere pulses a load strobe once per word period. On each strobe the block captures the word on its data input. It then presents the bits one per fast clock, starting with the highest-numbered bit. If strobes arrive every `WORD_W` cycles, each word follows the previous one with no idle bit between them.

There are two outputs, and both are registered. The primary output can be inverted by an active-low polarity control. The loopback output carries a second copy of the stream for system loopback. It is gated by an active-low enable and always has true polarity. While the synchronous active-high reset is sampled high, the shift register is cleared and both outputs are driven low. Reset should be held for at least 64 fast clocks so that every upstream stage is also clear.

Top module: `sermux16_msb`

## Requirements
- R1: When `word_ld` is sampled high at clock edge k, bit `WORD_W-1` of the captured word appears on the primary path at edge k+1. With `inv_n` high, this means `ser_o` equals that bit after edge k+1.
- R2: The bits of a captured word leave in descending index order: after edge k+1+i the primary path carries bit `WORD_W-1-i`, for i = 0 to `WORD_W-1`.
- R3: With a strobe every `WORD_W` cycles, the last bit of one word is followed on the very next edge by the first bit of the next word. No filler bit is inserted.
- R4: When no new strobe arrives after all `WORD_W` bits of a word have left, the primary path carries logic 0 (before any inversion) until the next strobe.
- R5: A strobe that arrives before the current word has finished discards the unsent bits. The new word starts on the following edge.
- R6: When `inv_n` is sampled low, `ser_o` is the complement of the path bit. When `inv_n` is sampled high, `ser_o` equals the path bit. `inv_n` is sampled on the same edge that registers the bit.
- R7: When `lb_en_n` is sampled low, `lpbk_o` equals the true-polarity path bit, whatever the level of `inv_n`.
- R8: When `lb_en_n` is sampled high, `lpbk_o` is 0 after that edge.
- R9: On every edge where `rst` is sampled high, `ser_o` and `lpbk_o` become 0, even with `inv_n` low. The shift register is cleared, so a path with no strobe after reset carries logic 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| word_ld | input | 1 | Word-load strobe from the clock divider |
| data_i | input | WORD_W | Parallel word captured when `word_ld` is high |
| inv_n | input | 1 | Primary output polarity; 0 inverts |
| lb_en_n | input | 1 | Loopback enable; 0 enables |
| ser_o | output | 1 | Primary serial bit, registered |
| lpbk_o | output | 1 | Loopback serial bit, registered, always true polarity |

## Verification
A wrong shift register state shows up at the ports on the next fast clock. Dropped, repeated or reordered bits shift the whole word against the model. A stale bit left after the last one of a word breaks the gap-free join or the zero fill at once. Polarity and gating faults show within one edge of a change on `inv_n` or `lb_en_n`. Comparing `lpbk_o` with `ser_o` separates a fault in the output stage from a fault in the data path.

// File: rtl/sermux_pkg.sv
package sermux_pkg;

  // Registered pair of serial outputs
  typedef struct packed {
    logic pri;
    logic lpbk;
  } ser_pair_t;

  // Polarity applied to the primary lane (active-low invert control)
  function automatic logic apply_pol(input logic b, input logic inv_n);
    return b ^ ~inv_n;
  endfunction

  // Loopback gate (active-low enable), true polarity only
  function automatic logic gate_lb(input logic b, input logic en_n);
    return b & ~en_n;
  endfunction

endpackage

// File: rtl/sermux_shift.sv
module sermux_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  output logic              msb_o
);

  localparam int TOP = WORD_W - 1;

  logic [WORD_W-1:0] sr_q;

  // One flop per slice; bit 0 takes a zero fill when shifting
  for (genvar g = 0; g < WORD_W; g++) begin : g_slice
    logic fill;
    if (g == 0) begin : g_low
      assign fill = 1'b0;
    end else begin : g_up
      assign fill = sr_q[g-1];
    end

    always_ff @(posedge clk) begin
      if (rst)       sr_q[g] <= 1'b0;
      else if (load) sr_q[g] <= din[g];
      else           sr_q[g] <= fill;
    end
  end

  assign msb_o = sr_q[TOP];

endmodule

// File: rtl/sermux_drive.sv
module sermux_drive
  import sermux_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_i,
  input  logic inv_n,
  input  logic lb_en_n,
  output logic ser_o,
  output logic lpbk_o
);

  ser_pair_t out_q;
  ser_pair_t out_d;

  always_comb begin
    out_d.pri  = apply_pol(bit_i, inv_n);
    out_d.lpbk = gate_lb(bit_i, lb_en_n);
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= out_d;
  end

  assign ser_o  = out_q.pri;
  assign lpbk_o = out_q.lpbk;

endmodule

// File: rtl/sermux16_msb.sv
module sermux16_msb #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_ld,
  input  logic [WORD_W-1:0] data_i,
  input  logic              inv_n,
  input  logic              lb_en_n,
  output logic              ser_o,
  output logic              lpbk_o
);

  logic path_bit;

  sermux_shift #(.WORD_W(WORD_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (word_ld),
    .din   (data_i),
    .msb_o (path_bit)
  );

  sermux_drive u_drive (
    .clk     (clk),
    .rst     (rst),
    .bit_i   (path_bit),
    .inv_n   (inv_n),
    .lb_en_n (lb_en_n),
    .ser_o   (ser_o),
    .lpbk_o  (lpbk_o)
  );

endmodule

// File: rtl/sermux16_msb_chk.sv
module sermux16_msb_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              word_ld,
  input logic [WORD_W-1:0] data_i,
  input logic              inv_n,
  input logic              lb_en_n,
  input logic              ser_o,
  input logic              lpbk_o
);

  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  // R9
  always @(negedge clk) begin
    if (rst_seen) begin
      reset_low_chk: assert (ser_o == 1'b0 && lpbk_o == 1'b0);
    end
  end

  // R8
  lb_gated_chk: assert property (@(posedge clk) disable iff (rst)
    $past(lb_en_n) |-> (lpbk_o == 1'b0));

  // R7
  lb_true_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(lb_en_n) && $past(inv_n)) |-> (lpbk_o == ser_o));

  // R6
  inv_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(lb_en_n) && !$past(inv_n)) |-> (lpbk_o != ser_o));

  // R1
  first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(word_ld, 2)) |->
      (ser_o == ($past(data_i[WORD_W-1], 2) ^ ~$past(inv_n))));

endmodule

bind sermux16_msb sermux16_msb_chk #(.WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .word_ld (word_ld),
  .data_i  (data_i),
  .inv_n   (inv_n),
  .lb_en_n (lb_en_n),
  .ser_o   (ser_o),
  .lpbk_o  (lpbk_o)
);

// File: tb/sermux16_msb_tb_top.sv
`timescale 1ns/1ps
module sermux16_msb_tb_top;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         word_ld = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         inv_n = 1'b0;
  logic         lb_en_n = 1'b0;
  logic         ser_o, lpbk_o;

  int    n_checks = 0;
  int    n_fails = 0;
  string phase = "R9";
  bit    started = 0;
  bit    finished = 0;

  bit    q[$];
  logic  exp_pri = 1'b0;
  logic  exp_lb = 1'b0;

  always #2.5 clk = ~clk;

  sermux16_msb #(.WORD_W(W)) dut_i (
    .clk(clk), .rst(rst), .word_ld(word_ld), .data_i(data_i),
    .inv_n(inv_n), .lb_en_n(lb_en_n), .ser_o(ser_o), .lpbk_o(lpbk_o)
  );

  // Behavioural reference: queue of bits waiting to leave
  always @(posedge clk) begin
    bit head;
    head = (q.size() != 0) ? q[0] : 1'b0;
    if (rst) begin
      exp_pri = 1'b0;
      exp_lb  = 1'b0;
      q.delete();
    end else begin
      exp_pri = head ^ ~inv_n;
      exp_lb  = lb_en_n ? 1'b0 : head;
      if (word_ld) begin
        q.delete();
        for (int i = W-1; i >= 0; i--) q.push_back(data_i[i]);
      end else if (q.size() != 0) begin
        void'(q.pop_front());
      end
    end
    started = 1;
  end

  task automatic check(input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      check(ser_o, exp_pri, "ser_o");
      check(lpbk_o, exp_lb, "lpbk_o");
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [W-1:0] d, input int len);
    @(negedge clk);
    word_ld = 1'b1;
    data_i  = d;
    @(negedge clk);
    word_ld = 1'b0;
    data_i  = ~d;
    idle(len - 2);
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    // R9: reset held 64 cycles, output low even with invert active
    phase = "R9"; inv_n = 1'b0; lb_en_n = 1'b0;
    idle(64);
    @(negedge clk); rst = 1'b0;
    // R4 / R9: cleared path carries zero after release
    phase = "R4"; inv_n = 1'b1;
    idle(6);
    // R1: single word after idle
    phase = "R1";
    send(16'h8000, W);
    // R2 / R3: back-to-back words, loopback enabled
    phase = "R2";
    send(16'hA5C3, W);
    send(16'h1234, W);
    phase = "R3";
    send(16'h0001, W);
    send(16'h8001, W);
    send(16'hFFFF, W);
    send(16'h0000, W);
    // R6 / R7: inverted primary, true loopback
    phase = "R6"; inv_n = 1'b0;
    send(16'hC0DE, W);
    phase = "R7";
    send(16'h5A5A, W);
    // R8: loopback gated off
    phase = "R8"; lb_en_n = 1'b1;
    send(16'hFFFF, W);
    send(16'h7E81, W);
    inv_n = 1'b1;
    send(16'hBEEF, W);
    lb_en_n = 1'b0;
    // R5: strobe before the word has finished
    phase = "R5";
    send(16'hF0F0, 5);
    send(16'h0FF1, 9);
    send(16'hAAAA, W);
    // R4: no further strobe, zero fill
    phase = "R4";
    idle(2*W);
    inv_n = 1'b0;
    idle(4);
    // R9: reset in mid-stream
    phase = "R9";
    send(16'hFFFF, 6);
    rst = 1'b1;
    idle(8);
    @(negedge clk); rst = 1'b0;
    idle(4);
    idle(2);
    summary();
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=running expected=done");
      summary();
    end
  end

endmodule